// File: doc/BRIEF.md
# Flash End-of-Write Polling Engine

This block sits on the host side of a parallel NOR flash. It starts after the controller has issued the last write pulse of a program or erase command. It then reads one chosen location over and over until the internal operation of the flash is finished, and reports the result to the logic that made the request. It does not build command sequences and does not drive bus timing. Each read goes through a simple request/acknowledge port to a separate bus interface.

Two detection methods are supported:
- **Inverted-data polling on bit 7.** For a program, completion is the read bit 7 matching bit 7 of the word that was written. For an erase, completion is the read bit 7 being 1.
- **Toggle polling on bit 6.** Completion is bit 6 staying the same on two reads in a row.

The end of the operation is not synchronised to the host, so a read can land on the exact moment of completion and give a false result. For that reason an apparent completion is only accepted after two more reads of the same location also pass. If either of those reads fails, the engine reports a rejection. Programming of the security-ID area is always polled with the toggle method, whatever mode is requested. A cycle-count limit chosen by operation type bounds each poll.

Top module: `eow_poll_engine`

## Requirements
- R1: A `start_i` pulse is accepted only while `busy_o` is low. `busy_o` is high from the cycle after an accepted start until a result is reported. A `start_i` seen while busy has no effect on the running poll: its result and its read count are unchanged.
- R2: While busy, `rd_req_o` is held high. Every cycle in which both `rd_req_o` and `rd_ack_i` are high completes one read, with `rd_data_i` valid. While idle, `rd_req_o` is low.
- R3: Inverted-data mode with a program operation (`op_i` = 2'b00): a read is an apparent completion when its bit 7 equals bit 7 of `exp_data_i` as captured at start.
- R4: Inverted-data mode with a sector/block erase (`op_i` = 2'b01) or a chip erase (`op_i` = 2'b10): a read is an apparent completion when its bit 7 is 1.
- R5: Toggle mode (`use_toggle_i` = 1): a read is an apparent completion when its bit 6 equals bit 6 of the previous read in the same poll. The first read of a poll is never an apparent completion.
- R6: After an apparent completion, two more reads are made, and each must pass the same test (in toggle mode, each is compared with the read just before it). If both pass, `done_o` is raised. If the first or second confirmation read fails, `err_o` is raised right after that read. A failing read before any apparent completion just continues the poll.
- R7: A security-ID program (`op_i` = 2'b11) is always polled in toggle mode, even when `use_toggle_i` is 0.
- R8: Program and security-ID program use `PROG_LIMIT`, sector/block erase uses `BLK_LIMIT`, and chip erase uses `CHIP_LIMIT`. If no result has been reached after that many busy cycles, `timeout_o` is raised and the engine returns to idle. `busy_o` is high for exactly that many cycles.
- R9: `done_o`, `err_o` and `timeout_o` are single-cycle pulses. At most one of them is high at a time, and each appears in the first idle cycle after the poll ends.
- R10: During and after reset the engine is idle: `busy_o`, `rd_req_o`, `done_o`, `err_o` and `timeout_o` are all low. A reset during a poll abandons it with no result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (accepted in idle only) |
| op_i | input | 2 | 00 program, 01 sector/block erase, 10 chip erase, 11 security-ID program |
| use_toggle_i | input | 1 | 1 selects toggle polling, 0 selects inverted-data polling |
| exp_data_i | input | DW | Word that was programmed |
| rd_req_o | output | 1 | Read request toward the bus interface |
| rd_ack_i | input | 1 | Read complete, data valid |
| rd_data_i | input | DW | Word read from the polled address |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | Completion confirmed (pulse) |
| err_o | output | 1 | Apparent completion rejected (pulse) |
| timeout_o | output | 1 | Limit expired (pulse) |

## Verification
A wrong confirmation count shows up directly as a read total that is off by one or more reads when the done pulse arrives. A lost or stale toggle reference shifts the apparent completion by one read, or makes a glitching read pass as a finished one, within the next three handshakes. A wrong limit or wrong limit selection moves the timeout pulse away from the exact busy-cycle count of its operation type. A latched mode that ignores the security-ID override ends the poll after three reads instead of after the toggle has settled.

// File: rtl/eow_pkg.sv
package eow_pkg;

    typedef enum logic [1:0] {
        OP_PROG       = 2'b00,
        OP_BLK_ERASE  = 2'b01,
        OP_CHIP_ERASE = 2'b10,
        OP_SECID_PROG = 2'b11
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_POLL = 1'b1
    } state_e;

endpackage

// File: rtl/eow_status_judge.sv
module eow_status_judge #(
    parameter int DW       = 16,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic          tog_mode_i,
    input  logic          erase_i,
    input  logic          exp_bit_i,
    input  logic          prev_valid_i,
    input  logic          prev_tog_i,
    input  logic [DW-1:0] word_i,
    output logic          hit_o
);

    always_comb begin
        if (tog_mode_i) begin
            hit_o = prev_valid_i && (word_i[TOG_BIT] == prev_tog_i);
        end else if (erase_i) begin
            hit_o = word_i[POLL_BIT];
        end else begin
            hit_o = (word_i[POLL_BIT] == exp_bit_i);
        end
    end

endmodule

// File: rtl/eow_timeout_timer.sv
module eow_timeout_timer #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          run_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = run_i && (cnt_q >= limit_i - 1'b1);

    // R8
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/eow_poll_engine.sv
module eow_poll_engine
    import eow_pkg::*;
#(
    parameter int DW         = 16,
    parameter int POLL_BIT   = 7,
    parameter int TOG_BIT    = 6,
    parameter int CW         = 24,
    parameter int PROG_LIMIT = 2400,
    parameter int BLK_LIMIT  = 5000000,
    parameter int CHIP_LIMIT = 12000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    op_i,
    input  logic          use_toggle_i,
    input  logic [DW-1:0] exp_data_i,
    output logic          rd_req_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic          timeout_o
);

    localparam int CONFIRM_READS = 2;
    localparam int KW            = $clog2(CONFIRM_READS + 1);
    localparam logic [CW-1:0] PROG_LIM_C = CW'(PROG_LIMIT);
    localparam logic [CW-1:0] BLK_LIM_C  = CW'(BLK_LIMIT);
    localparam logic [CW-1:0] CHIP_LIM_C = CW'(CHIP_LIMIT);

    typedef struct packed {
        state_e        st;
        op_e           op;
        logic          tog;
        logic [DW-1:0] exp;
        logic [KW-1:0] conf;
        logic          prev_valid;
        logic          prev_tog;
        logic          done;
        logic          err;
        logic          tmo;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          hit;
    logic          expired;
    logic          tmr_clear;
    logic          is_erase;
    logic [CW-1:0] limit_sel;

    assign is_erase = (ctl_q.op == OP_BLK_ERASE) || (ctl_q.op == OP_CHIP_ERASE);

    always_comb begin
        case (ctl_q.op)
            OP_BLK_ERASE:  limit_sel = BLK_LIM_C;
            OP_CHIP_ERASE: limit_sel = CHIP_LIM_C;
            default:       limit_sel = PROG_LIM_C;
        endcase
    end

    eow_status_judge #(
        .DW       (DW),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_judge (
        .tog_mode_i   (ctl_q.tog),
        .erase_i      (is_erase),
        .exp_bit_i    (ctl_q.exp[POLL_BIT]),
        .prev_valid_i (ctl_q.prev_valid),
        .prev_tog_i   (ctl_q.prev_tog),
        .word_i       (rd_data_i),
        .hit_o        (hit)
    );

    eow_timeout_timer #(
        .CW (CW)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (tmr_clear),
        .run_i     (ctl_q.st == ST_POLL),
        .limit_i   (limit_sel),
        .expired_o (expired)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        ctl_d.tmo  = 1'b0;
        tmr_clear  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st         = ST_POLL;
                    ctl_d.op         = op_e'(op_i);
                    ctl_d.tog        = use_toggle_i || (op_e'(op_i) == OP_SECID_PROG);
                    ctl_d.exp        = exp_data_i;
                    ctl_d.conf       = '0;
                    ctl_d.prev_valid = 1'b0;
                    tmr_clear        = 1'b1;
                end
            end
            default: begin
                if (rd_ack_i) begin
                    ctl_d.prev_valid = 1'b1;
                    ctl_d.prev_tog   = rd_data_i[TOG_BIT];
                    if (hit) begin
                        if (ctl_q.conf == KW'(CONFIRM_READS)) begin
                            ctl_d.done = 1'b1;
                            ctl_d.st   = ST_IDLE;
                        end else begin
                            ctl_d.conf = ctl_q.conf + 1'b1;
                        end
                    end else if (ctl_q.conf != '0) begin
                        ctl_d.err = 1'b1;
                        ctl_d.st  = ST_IDLE;
                    end
                end
                if (expired && (ctl_d.st == ST_POLL)) begin
                    ctl_d.tmo = 1'b1;
                    ctl_d.st  = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, op: OP_PROG, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o    = (ctl_q.st == ST_POLL);
    assign rd_req_o  = (ctl_q.st == ST_POLL);
    assign done_o    = ctl_q.done;
    assign err_o     = ctl_q.err;
    assign timeout_o = ctl_q.tmo;

    // R9
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_o, timeout_o}));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o || timeout_o) |=> !(done_o || err_o || timeout_o));

    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R6
    verdict_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |-> $past(rd_req_o && rd_ack_i));

    // R8
    result_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o || timeout_o) |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/tb_eow_poll_engine.sv
module tb_eow_poll_engine;

    localparam int DW = 16;
    localparam int PL = 200;
    localparam int BL = 300;
    localparam int CL = 500;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    op_i = 2'b00;
    logic          use_toggle_i = 1'b0;
    logic [DW-1:0] exp_data_i = '0;
    logic          rd_req_o;
    logic          rd_ack_i;
    logic [DW-1:0] rd_data_i;
    logic          busy_o, done_o, err_o, timeout_o;

    always #2.5 clk = ~clk;

    eow_poll_engine #(
        .DW (DW), .CW (24),
        .PROG_LIMIT (PL), .BLK_LIMIT (BL), .CHIP_LIMIT (CL)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .op_i (op_i),
        .use_toggle_i (use_toggle_i), .exp_data_i (exp_data_i),
        .rd_req_o (rd_req_o), .rd_ack_i (rd_ack_i), .rd_data_i (rd_data_i),
        .busy_o (busy_o), .done_o (done_o), .err_o (err_o), .timeout_o (timeout_o)
    );

    int checks = 0;
    int errors = 0;

    // flash model state
    logic [1:0]  m_op;
    logic [15:0] m_exp, m_nbusy, m_gat, m_idx;
    logic [3:0]  m_glen;
    logic        m_slow, m_s, m_ph;

    function automatic logic [15:0] done_word(input logic [1:0] op, input logic [15:0] e);
        return (op == 2'b01 || op == 2'b10) ? 16'hFFFF : e;
    endfunction

    initial begin
        rd_ack_i = 1'b0; rd_data_i = '0;
        m_op = 0; m_exp = 0; m_nbusy = 0; m_gat = 16'hFFFF; m_glen = 0;
        m_idx = 0; m_slow = 0; m_s = 0; m_ph = 0;
        forever begin
            @(negedge clk);
            m_ph = ~m_ph;
            if (rd_req_o && !(m_slow && m_ph)) begin
                logic [15:0] w;
                logic b7;
                w = '0;
                if (m_gat != 16'hFFFF && m_idx >= m_gat && m_idx < m_gat + 16'(m_glen)) begin
                    b7 = (m_op == 2'b01 || m_op == 2'b10) ? 1'b1 : m_exp[7];
                    w[7] = b7; w[6] = m_s;
                end else if (m_idx < m_nbusy) begin
                    m_s = ~m_s;
                    case (m_op)
                        2'b00:   b7 = ~m_exp[7];
                        2'b11:   b7 = m_exp[7];
                        default: b7 = 1'b0;
                    endcase
                    w[7] = b7; w[6] = m_s;
                end else begin
                    w = done_word(m_op, m_exp);
                end
                rd_data_i = w;
                rd_ack_i  = 1'b1;
                m_idx     = m_idx + 1'b1;
            end else begin
                rd_ack_i = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // res: 0 done, 1 err, 2 timeout; cnt: reads (done/err) or busy cycles (timeout)
    task automatic run_poll(input logic [1:0] op, input logic tog, input logic [15:0] e,
                            input logic [15:0] nb, input logic [15:0] gat, input logic [3:0] gl,
                            input logic slow, input int res, input int cnt,
                            input bit poke, input string req);
        int busy_cnt;
        int got;
        int it;
        @(negedge clk);
        m_op = op; m_exp = e; m_nbusy = nb; m_gat = gat; m_glen = gl;
        m_slow = slow; m_idx = 0; m_s = 0;
        op_i = op; use_toggle_i = tog; exp_data_i = e; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        busy_cnt = 0; got = -1; it = 0;
        while (it < 4000) begin
            if (done_o) got = 0;
            else if (err_o) got = 1;
            else if (timeout_o) got = 2;
            if (got >= 0) break;
            if (busy_o) busy_cnt++;
            if (poke && it == 2) begin
                start_i = 1'b1; op_i = 2'b10; use_toggle_i = ~tog; exp_data_i = ~e;
            end else begin
                start_i = 1'b0;
            end
            it++;
            @(negedge clk);
        end
        start_i = 1'b0;
        check(got == res, req, "result code", got, res);
        if (res == 2) check(busy_cnt == cnt, req, "busy cycles", busy_cnt, cnt);
        else check(int'(m_idx) == cnt, req, "reads", int'(m_idx), cnt);
        @(negedge clk);
        // R9 single-cycle pulse
        check(!(done_o || err_o || timeout_o || busy_o), "R9", "flags after pulse",
              int'({done_o, err_o, timeout_o, busy_o}), 0);
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic        tog;
        logic [15:0] e;
        logic [15:0] nb;
        logic [15:0] gat;
        logic [3:0]  gl;
        logic        slow;
        logic [1:0]  res;
        logic [15:0] cnt;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 16'h1234, 16'd5,     16'hFFFF, 4'd0, 1'b0, 2'd0, 16'd8},   // R3
        '{2'b00, 1'b0, 16'h00A5, 16'd0,     16'hFFFF, 4'd0, 1'b0, 2'd0, 16'd3},   // R3
        '{2'b01, 1'b0, 16'h0000, 16'd4,     16'hFFFF, 4'd0, 1'b0, 2'd0, 16'd7},   // R4
        '{2'b10, 1'b0, 16'h0000, 16'd10,    16'hFFFF, 4'd0, 1'b1, 2'd0, 16'd13},  // R4 R2
        '{2'b00, 1'b1, 16'h1234, 16'd5,     16'hFFFF, 4'd0, 1'b0, 2'd0, 16'd9},   // R5
        '{2'b00, 1'b1, 16'h0040, 16'd5,     16'hFFFF, 4'd0, 1'b0, 2'd0, 16'd8},   // R5
        '{2'b01, 1'b1, 16'h0000, 16'd4,     16'hFFFF, 4'd0, 1'b0, 2'd0, 16'd8},   // R5
        '{2'b11, 1'b0, 16'h0080, 16'd6,     16'hFFFF, 4'd0, 1'b0, 2'd0, 16'd9},   // R7
        '{2'b00, 1'b0, 16'h1234, 16'd6,     16'd3,    4'd1, 1'b0, 2'd1, 16'd5},   // R6
        '{2'b00, 1'b0, 16'h1234, 16'd6,     16'd2,    4'd2, 1'b0, 2'd1, 16'd5},   // R6
        '{2'b01, 1'b1, 16'h0000, 16'd8,     16'd3,    4'd1, 1'b0, 2'd1, 16'd5},   // R6
        '{2'b00, 1'b0, 16'h1234, 16'hFFFF,  16'hFFFF, 4'd0, 1'b0, 2'd2, 16'd200}, // R8
        '{2'b10, 1'b0, 16'h0000, 16'hFFFF,  16'hFFFF, 4'd0, 1'b1, 2'd2, 16'd500}, // R8
        '{2'b01, 1'b1, 16'h0000, 16'hFFFF,  16'hFFFF, 4'd0, 1'b0, 2'd2, 16'd300}, // R8
        '{2'b11, 1'b0, 16'h0000, 16'hFFFF,  16'hFFFF, 4'd0, 1'b0, 2'd2, 16'd200}, // R8 R7
        '{2'b00, 1'b1, 16'h0040, 16'd0,     16'hFFFF, 4'd0, 1'b0, 2'd0, 16'd4}    // R5
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!(busy_o || rd_req_o || done_o || err_o || timeout_o), "R10", "outputs in reset",
              int'({busy_o, rd_req_o, done_o, err_o, timeout_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!(busy_o || rd_req_o), "R10", "idle after reset", int'({busy_o, rd_req_o}), 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            case (i)
                0, 1:         tag = "R3";
                2, 3:         tag = "R4";
                4, 5, 6, 15:  tag = "R5";
                7:            tag = "R7";
                8, 9, 10:     tag = "R6";
                default:      tag = "R8";
            endcase
            run_poll(VECS[i].op, VECS[i].tog, VECS[i].e, VECS[i].nb, VECS[i].gat,
                     VECS[i].gl, VECS[i].slow, int'(VECS[i].res), int'(VECS[i].cnt), 1'b0, tag);
        end

        // R1 start while busy is ignored
        run_poll(2'b00, 1'b0, 16'h1234, 16'd5, 16'hFFFF, 4'd0, 1'b0, 0, 8, 1'b1, "R1");

        // R2 request idle when not polling
        @(negedge clk);
        check(!rd_req_o, "R2", "no request in idle", int'(rd_req_o), 0);

        // R10 reset during a poll
        @(negedge clk);
        m_op = 2'b00; m_exp = 16'h1234; m_nbusy = 16'hFFFF; m_gat = 16'hFFFF;
        m_slow = 0; m_idx = 0; m_s = 0;
        op_i = 2'b00; use_toggle_i = 1'b0; exp_data_i = 16'h1234; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && rd_req_o, "R2", "request while busy", int'({busy_o, rd_req_o}), 3);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!(busy_o || done_o || err_o || timeout_o), "R10", "abandon on reset",
              int'({busy_o, done_o, err_o, timeout_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!(done_o || err_o || timeout_o || busy_o), "R10", "no pulse after reset",
              int'({done_o, err_o, timeout_o, busy_o}), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule